// File: doc/BRIEF.md
# Per-Cycle Clock Edge Shrink Controller

This block controls a clock-edge manipulation feature used in silicon timing debug. It sits beside a programmable edge delay buffer and drives two separate delay codes: one for the buffer's rising edge and one for its falling edge. By moving one edge and not the other for a chosen clock, the duty cycle of a single cycle can be changed. This can shrink a high phase, shrink a low phase, or shorten a whole period while the duty cycle stays at half.

Software first loads a target cycle number, a schedule of up to four rise/fall code pairs, the index of the last pair used, and the default code pair. It then arms the block. A free-running cycle counter is compared with the target. In the cycle after they match, the controller presents the schedule one pair per clock. It then holds the final pair until software re-arms the block or restores the defaults. An active flag marks the cycles in which schedule pairs are on the outputs.

Top module: `edge_shrink_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, both code outputs equal the parameter default (7) and the active flag is low.
- R2: Every code ever driven lies in 0..13 (fourteen linear steps). A programmed code above 13 is stored and driven as 13.
- R3: A load request is taken only when the block is neither armed nor running. A load while armed or running changes no stored setting, so the schedule that later plays is the earlier one.
- R4: The cycle counter holds 0 in the first cycle after reset and then increases by one per clock. Schedule entry 0 appears on the outputs in the cycle after the counter equals the stored target.
- R5: Entries 0..L play on consecutive cycles, one per cycle, where L is the stored last-entry index. Rise and fall codes come from their own fields: entry k has its rise code at prog_rise bits [4k+3:4k] and its fall code at prog_fall bits [4k+3:4k].
- R6: sched_active is high in exactly the L+1 cycles that show schedule entries, and low at all other times.
- R7: After the last entry the outputs keep the last entry's codes, with active low, until restore or a new arm.
- R8: A restore pulse returns both outputs to the stored default codes on the next cycle and cancels any armed trigger.
- R9: The trigger needs the counter to equal the target exactly, and it fires at most once per arm. A target that has already passed never fires, and an arm pulse while armed or running is ignored.
- R10: While idle or armed, the outputs show the stored default codes. A new default therefore reaches the outputs two cycles after its load cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prog_load | input | 1 | Load request for all programming fields |
| prog_target | input | 32 | Cycle number that starts the schedule |
| prog_last | input | 2 | Index of the last schedule entry used |
| prog_rise | input | 16 | Rise codes, entry k in bits [4k+3:4k] |
| prog_fall | input | 16 | Fall codes, entry k in bits [4k+3:4k] |
| prog_def_rise | input | 4 | Default rise code |
| prog_def_fall | input | 4 | Default fall code |
| arm | input | 1 | Arm pulse |
| restore | input | 1 | Return to defaults and disarm |
| rise_code | output | 4 | Rising-edge delay code to the buffer |
| fall_code | output | 4 | Falling-edge delay code to the buffer |
| sched_active | output | 1 | High while schedule entries are driven |

## Verification
The bound checker checks these on every cycle: codes stay in range, the active flag rises only in the cycle after a counter/target match, the entry index never passes the stored last index, the held codes stay stable, stored settings stay frozen under a load while armed or running, and restore drops the flag. Only the bench scenarios can show the rest. That covers the exact code pairs in the example high-phase shrink and in a four-entry period shrink, the saturation values, that a schedule loaded while armed is discarded, that a target already passed never fires, and that an arm pulse during a run has no effect. The bench model runs alongside the design on every cycle to confirm these.

// File: rtl/edge_shrink_pkg.sv
package edge_shrink_pkg;
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_ARMED = 2'd1,
        PH_RUN   = 2'd2,
        PH_HOLD  = 2'd3
    } shrink_phase_e;
endpackage

// File: rtl/edge_cycle_counter.sv
module edge_cycle_counter #(
    parameter int CYC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CYC_W-1:0] count
);
    logic [CYC_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q + CYC_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;
endmodule

// File: rtl/edge_shrink_bank.sv
module edge_shrink_bank #(
    parameter int CODE_W   = 4,
    parameter int N_STEPS  = 14,
    parameter int N_SLOTS  = 4,
    parameter int CYC_W    = 32,
    parameter int IDX_W    = 2,
    parameter int DEF_CODE = 7
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             load_en,
    input  logic [CYC_W-1:0]                 target_in,
    input  logic [IDX_W-1:0]                 last_in,
    input  logic [N_SLOTS*CODE_W-1:0]        rise_in,
    input  logic [N_SLOTS*CODE_W-1:0]        fall_in,
    input  logic [CODE_W-1:0]                def_rise_in,
    input  logic [CODE_W-1:0]                def_fall_in,
    output logic [CYC_W-1:0]                 target_q,
    output logic [IDX_W-1:0]                 last_q,
    output logic [N_SLOTS-1:0][CODE_W-1:0]   rise_tab,
    output logic [N_SLOTS-1:0][CODE_W-1:0]   fall_tab,
    output logic [CODE_W-1:0]                def_rise_q,
    output logic [CODE_W-1:0]                def_fall_q
);
    localparam logic [CODE_W-1:0] MAX_CODE = CODE_W'(N_STEPS - 1);
    localparam logic [CODE_W-1:0] RST_CODE = CODE_W'(DEF_CODE);

    typedef struct packed {
        logic [CYC_W-1:0]               target;
        logic [IDX_W-1:0]               last;
        logic [N_SLOTS-1:0][CODE_W-1:0] rise;
        logic [N_SLOTS-1:0][CODE_W-1:0] fall;
        logic [CODE_W-1:0]              drise;
        logic [CODE_W-1:0]              dfall;
    } bank_t;

    bank_t bank_d, bank_q;
    logic [N_SLOTS-1:0][CODE_W-1:0] sat_rise, sat_fall;

    function automatic logic [CODE_W-1:0] clip(input logic [CODE_W-1:0] v);
        return (v > MAX_CODE) ? MAX_CODE : v;
    endfunction

    for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
        assign sat_rise[g] = clip(rise_in[g*CODE_W +: CODE_W]);
        assign sat_fall[g] = clip(fall_in[g*CODE_W +: CODE_W]);
    end

    always_comb begin
        bank_d = bank_q;
        if (load_en) begin
            bank_d.target = target_in;
            bank_d.last   = last_in;
            bank_d.rise   = sat_rise;
            bank_d.fall   = sat_fall;
            bank_d.drise  = clip(def_rise_in);
            bank_d.dfall  = clip(def_fall_in);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q.target <= '0;
            bank_q.last   <= '0;
            bank_q.rise   <= {N_SLOTS{RST_CODE}};
            bank_q.fall   <= {N_SLOTS{RST_CODE}};
            bank_q.drise  <= RST_CODE;
            bank_q.dfall  <= RST_CODE;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign target_q   = bank_q.target;
    assign last_q     = bank_q.last;
    assign rise_tab   = bank_q.rise;
    assign fall_tab   = bank_q.fall;
    assign def_rise_q = bank_q.drise;
    assign def_fall_q = bank_q.dfall;
endmodule

// File: rtl/edge_shrink_ctrl.sv
module edge_shrink_ctrl
    import edge_shrink_pkg::*;
#(
    parameter int CODE_W   = 4,
    parameter int N_STEPS  = 14,
    parameter int N_SLOTS  = 4,
    parameter int CYC_W    = 32,
    parameter int DEF_CODE = 7,
    localparam int IDX_W   = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      prog_load,
    input  logic [CYC_W-1:0]          prog_target,
    input  logic [IDX_W-1:0]          prog_last,
    input  logic [N_SLOTS*CODE_W-1:0] prog_rise,
    input  logic [N_SLOTS*CODE_W-1:0] prog_fall,
    input  logic [CODE_W-1:0]         prog_def_rise,
    input  logic [CODE_W-1:0]         prog_def_fall,
    input  logic                      arm,
    input  logic                      restore,
    output logic [CODE_W-1:0]         rise_code,
    output logic [CODE_W-1:0]         fall_code,
    output logic                      sched_active
);
    typedef struct packed {
        shrink_phase_e       phase;
        logic [IDX_W-1:0]    idx;
        logic [CODE_W-1:0]   rise;
        logic [CODE_W-1:0]   fall;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [CYC_W-1:0]               cyc_q;
    logic [CYC_W-1:0]               target_q;
    logic [IDX_W-1:0]               last_q;
    logic [N_SLOTS-1:0][CODE_W-1:0] rise_tab, fall_tab;
    logic [CODE_W-1:0]              def_rise_q, def_fall_q;
    logic                           load_ok;
    logic                           hit;
    logic [IDX_W-1:0]               idx_nx;
    shrink_phase_e                  phase_q;
    logic [IDX_W-1:0]               idx_q;

    assign load_ok = prog_load && (ctl_q.phase == PH_IDLE || ctl_q.phase == PH_HOLD);
    assign hit     = (cyc_q == target_q);
    assign idx_nx  = ctl_q.idx + IDX_W'(1);

    edge_cycle_counter #(.CYC_W(CYC_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .count (cyc_q)
    );

    edge_shrink_bank #(
        .CODE_W   (CODE_W),
        .N_STEPS  (N_STEPS),
        .N_SLOTS  (N_SLOTS),
        .CYC_W    (CYC_W),
        .IDX_W    (IDX_W),
        .DEF_CODE (DEF_CODE)
    ) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_en     (load_ok),
        .target_in   (prog_target),
        .last_in     (prog_last),
        .rise_in     (prog_rise),
        .fall_in     (prog_fall),
        .def_rise_in (prog_def_rise),
        .def_fall_in (prog_def_fall),
        .target_q    (target_q),
        .last_q      (last_q),
        .rise_tab    (rise_tab),
        .fall_tab    (fall_tab),
        .def_rise_q  (def_rise_q),
        .def_fall_q  (def_fall_q)
    );

    always_comb begin
        ctl_d = ctl_q;
        if (restore) begin
            ctl_d.phase = PH_IDLE;
            ctl_d.idx   = '0;
            ctl_d.rise  = def_rise_q;
            ctl_d.fall  = def_fall_q;
        end else begin
            unique case (ctl_q.phase)
                PH_IDLE: begin
                    ctl_d.rise = def_rise_q;
                    ctl_d.fall = def_fall_q;
                    if (arm) ctl_d.phase = PH_ARMED;
                end
                PH_ARMED: begin
                    if (hit) begin
                        ctl_d.phase = PH_RUN;
                        ctl_d.idx   = '0;
                        ctl_d.rise  = rise_tab[0];
                        ctl_d.fall  = fall_tab[0];
                    end else begin
                        ctl_d.rise = def_rise_q;
                        ctl_d.fall = def_fall_q;
                    end
                end
                PH_RUN: begin
                    if (ctl_q.idx >= last_q) begin
                        ctl_d.phase = PH_HOLD;
                    end else begin
                        ctl_d.idx  = idx_nx;
                        ctl_d.rise = rise_tab[idx_nx];
                        ctl_d.fall = fall_tab[idx_nx];
                    end
                end
                PH_HOLD: begin
                    if (arm) begin
                        ctl_d.phase = PH_ARMED;
                        ctl_d.rise  = def_rise_q;
                        ctl_d.fall  = def_fall_q;
                    end
                end
                default: ctl_d.phase = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q.phase <= PH_IDLE;
            ctl_q.idx   <= '0;
            ctl_q.rise  <= CODE_W'(DEF_CODE);
            ctl_q.fall  <= CODE_W'(DEF_CODE);
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign phase_q      = ctl_q.phase;
    assign idx_q        = ctl_q.idx;
    assign rise_code    = ctl_q.rise;
    assign fall_code    = ctl_q.fall;
    assign sched_active = (ctl_q.phase == PH_RUN);
endmodule

// File: rtl/edge_shrink_ctrl_chk.sv
module edge_shrink_ctrl_chk
    import edge_shrink_pkg::*;
#(
    parameter int CODE_W  = 4,
    parameter int N_STEPS = 14,
    parameter int CYC_W   = 32,
    parameter int IDX_W   = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              restore,
    input logic              prog_load,
    input logic              sched_active,
    input logic [CODE_W-1:0] rise_code,
    input logic [CODE_W-1:0] fall_code,
    input shrink_phase_e     phase,
    input logic [IDX_W-1:0]  idx,
    input logic [IDX_W-1:0]  last,
    input logic [CYC_W-1:0]  cyc,
    input logic [CYC_W-1:0]  target
);
    localparam logic [CODE_W-1:0] MAX_CODE = CODE_W'(N_STEPS - 1);

    // R2
    code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_code <= MAX_CODE) && (fall_code <= MAX_CODE));

    // R3
    frozen_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_load && (phase == PH_ARMED || phase == PH_RUN)) |=> ($stable(target) && $stable(last)));

    // R4
    trigger_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sched_active) |-> $past(cyc == target));

    // R6
    entry_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sched_active |-> (idx <= last));

    // R7
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_HOLD && $past(phase) == PH_HOLD) |-> ($stable(rise_code) && $stable(fall_code)));

    // R8
    restore_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restore |=> !sched_active);
endmodule

bind edge_shrink_ctrl edge_shrink_ctrl_chk #(
    .CODE_W  (CODE_W),
    .N_STEPS (N_STEPS),
    .CYC_W   (CYC_W),
    .IDX_W   (IDX_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .restore      (restore),
    .prog_load    (prog_load),
    .sched_active (sched_active),
    .rise_code    (rise_code),
    .fall_code    (fall_code),
    .phase        (phase_q),
    .idx          (idx_q),
    .last         (last_q),
    .cyc          (cyc_q),
    .target       (target_q)
);

// File: tb/edge_shrink_ctrl_tb.sv
module edge_shrink_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        prog_load = 1'b0;
    logic [31:0] prog_target = '0;
    logic [1:0]  prog_last = '0;
    logic [15:0] prog_rise = '0;
    logic [15:0] prog_fall = '0;
    logic [3:0]  prog_def_rise = '0;
    logic [3:0]  prog_def_fall = '0;
    logic        arm = 1'b0;
    logic        restore = 1'b0;
    logic [3:0]  rise_code, fall_code;
    logic        sched_active;

    edge_shrink_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .prog_load(prog_load), .prog_target(prog_target),
        .prog_last(prog_last), .prog_rise(prog_rise), .prog_fall(prog_fall),
        .prog_def_rise(prog_def_rise), .prog_def_fall(prog_def_fall),
        .arm(arm), .restore(restore), .rise_code(rise_code),
        .fall_code(fall_code), .sched_active(sched_active)
    );

    always #5 clk = ~clk;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 0;

    task automatic chk(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // behavioural reference model
    bit m_arm, m_run, m_hold;
    int m_rise, m_fall;
    int q_r[$];
    int q_f[$];
    int s_target, s_last, s_dr, s_df;
    int s_r[4];
    int s_f[4];
    bit ld_ok;

    function automatic int sat(int v);
        return (v > 13) ? 13 : v;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_arm = 0; m_run = 0; m_hold = 0;
            m_rise = 7; m_fall = 7;
            q_r.delete(); q_f.delete();
            s_target = 0; s_last = 0; s_dr = 7; s_df = 7;
            for (int i = 0; i < 4; i++) begin s_r[i] = 7; s_f[i] = 7; end
            cyc = 0;
        end else begin
            ld_ok = prog_load && !m_arm && !m_run;
            if (restore) begin
                q_r.delete(); q_f.delete();
                m_arm = 0; m_run = 0; m_hold = 0;
                m_rise = s_dr; m_fall = s_df;
            end else if (m_run) begin
                if (q_r.size() > 0) begin
                    m_rise = q_r.pop_front();
                    m_fall = q_f.pop_front();
                end else begin
                    m_run = 0; m_hold = 1;
                end
            end else if (m_arm) begin
                if (cyc == s_target) begin
                    for (int i = 0; i <= s_last; i++) begin
                        q_r.push_back(s_r[i]);
                        q_f.push_back(s_f[i]);
                    end
                    m_rise = q_r.pop_front();
                    m_fall = q_f.pop_front();
                    m_run = 1; m_arm = 0;
                end else begin
                    m_rise = s_dr; m_fall = s_df;
                end
            end else if (arm) begin
                m_arm = 1; m_hold = 0;
                m_rise = s_dr; m_fall = s_df;
            end else if (!m_hold) begin
                m_rise = s_dr; m_fall = s_df;
            end
            if (ld_ok) begin
                s_target = int'(prog_target);
                s_last   = int'(prog_last);
                for (int i = 0; i < 4; i++) begin
                    s_r[i] = sat(int'(prog_rise[i*4 +: 4]));
                    s_f[i] = sat(int'(prog_fall[i*4 +: 4]));
                end
                s_dr = sat(int'(prog_def_rise));
                s_df = sat(int'(prog_def_fall));
            end
            cyc++;
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(m_run ? "R5 rise" : (m_hold ? "R7 rise" : "R10 rise"), int'(rise_code), m_rise);
            chk(m_run ? "R5 fall" : (m_hold ? "R7 fall" : "R10 fall"), int'(fall_code), m_fall);
            chk("R6 active", int'(sched_active), int'(m_run));
        end
    end

    task automatic load_cfg(int t, int lst, int r0, int r1, int r2, int r3,
                            int f0, int f1, int f2, int f3, int dr, int df);
        prog_target   = 32'(t);
        prog_last     = 2'(lst);
        prog_rise     = {4'(r3), 4'(r2), 4'(r1), 4'(r0)};
        prog_fall     = {4'(f3), 4'(f2), 4'(f1), 4'(f0)};
        prog_def_rise = 4'(dr);
        prog_def_fall = 4'(df);
        prog_load     = 1'b1;
        @(negedge clk);
        prog_load     = 1'b0;
    endtask

    task automatic pulse_arm();
        arm = 1'b1;
        @(negedge clk);
        arm = 1'b0;
    endtask

    task automatic pulse_restore();
        restore = 1'b1;
        @(negedge clk);
        restore = 1'b0;
    endtask

    task automatic wait_cyc(int c);
        while (cyc != c) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk("watchdog", 0, 1);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int t;
        @(negedge clk);
        // R1 reset state
        chk("R1 rise", int'(rise_code), 7);
        chk("R1 fall", int'(fall_code), 7);
        chk("R1 active", int'(sched_active), 0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 rise after reset", int'(rise_code), 7);
        chk("R4 counter start", cyc, 1);

        // high-phase shrink example: defaults 10/10, then (10,8),(8,8),(8,8)
        t = cyc + 12;
        load_cfg(t, 2, 10, 8, 8, 0, 8, 8, 8, 0, 10, 10);
        @(negedge clk);
        chk("R10 default rise", int'(rise_code), 10);
        pulse_arm();
        wait_cyc(t + 1);
        chk("R4 entry0 rise", int'(rise_code), 10);
        chk("R4 entry0 fall", int'(fall_code), 8);
        chk("R6 active entry0", int'(sched_active), 1);
        @(negedge clk);
        chk("R5 entry1 rise", int'(rise_code), 8);
        @(negedge clk);
        chk("R5 entry2 fall", int'(fall_code), 8);
        @(negedge clk);
        chk("R7 hold active low", int'(sched_active), 0);
        repeat (5) @(negedge clk);
        chk("R7 hold rise", int'(rise_code), 8);

        // R8 restore from hold
        pulse_restore();
        chk("R8 restore rise", int'(rise_code), 10);
        chk("R8 restore fall", int'(fall_code), 10);

        // R2 saturation
        t = cyc + 10;
        load_cfg(t, 0, 15, 0, 0, 0, 14, 0, 0, 0, 10, 10);
        pulse_arm();
        wait_cyc(t + 1);
        chk("R2 sat rise", int'(rise_code), 13);
        chk("R2 sat fall", int'(fall_code), 13);
        @(negedge clk);
        chk("R7 single entry done", int'(sched_active), 0);

        // R3 load while armed ignored (load accepted in hold first)
        t = cyc + 15;
        load_cfg(t, 1, 3, 5, 0, 0, 4, 6, 0, 0, 10, 10);
        pulse_arm();
        load_cfg(cyc + 3, 0, 1, 1, 1, 1, 1, 1, 1, 1, 2, 2);
        wait_cyc(t + 1);
        chk("R3 rise kept", int'(rise_code), 3);
        chk("R3 fall kept", int'(fall_code), 4);
        @(negedge clk);
        chk("R3 entry1 rise", int'(rise_code), 5);
        chk("R3 entry1 fall", int'(fall_code), 6);
        @(negedge clk);
        chk("R3 two entries only", int'(sched_active), 0);

        // R8 restore while armed cancels trigger
        pulse_restore();
        t = cyc + 10;
        load_cfg(t, 0, 1, 0, 0, 0, 2, 0, 0, 0, 9, 9);
        pulse_arm();
        repeat (3) @(negedge clk);
        pulse_restore();
        wait_cyc(t + 5);
        chk("R8 no trigger", int'(sched_active), 0);
        chk("R8 default rise", int'(rise_code), 9);

        // R9 target already passed never fires
        load_cfg(cyc - 3, 0, 1, 0, 0, 0, 1, 0, 0, 0, 9, 9);
        pulse_arm();
        repeat (20) @(negedge clk);
        chk("R9 past target", int'(sched_active), 0);
        chk("R9 past target rise", int'(rise_code), 9);
        pulse_restore();

        // R5/R9 four-entry period shrink, arm during run ignored
        t = cyc + 8;
        load_cfg(t, 3, 6, 3, 6, 3, 6, 3, 6, 3, 9, 9);
        pulse_arm();
        wait_cyc(t + 1);
        chk("R5 p0 rise", int'(rise_code), 6);
        pulse_arm();
        chk("R5 p1 fall", int'(fall_code), 3);
        @(negedge clk);
        chk("R5 p2 rise", int'(rise_code), 6);
        @(negedge clk);
        chk("R5 p3 rise", int'(rise_code), 3);
        chk("R6 p3 active", int'(sched_active), 1);
        @(negedge clk);
        chk("R9 arm in run ignored", int'(sched_active), 0);
        chk("R7 hold last", int'(fall_code), 3);
        repeat (5) @(negedge clk);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule